// File: doc/BRIEF.md
# UART Baud Clock Generator

This block makes the bit-rate clock for a UART transmitter and receiver. A single system clock drives all of the logic. One of four base-rate sources is turned into a stream of single-cycle enable pulses. Three of the sources are fixed power-of-two divisions of the system clock. The fourth is the rising edge of an external timer output, which is first brought into the clock domain through a two-stage synchronizer.

A 5-bit counter counts base pulses up to a programmable divisor k. Each time it reaches the end of its count, the baud output flips and a one-cycle strobe fires. The baud output therefore has a period of 2·k base pulses, and the strobe fires once per half period. Software programs the source and the divisor through one 8-bit configuration register, which it can also read back.

Dropping the enable, or writing the register, clears the prescaler, the divisor counter and the baud output. The count then starts again from zero.

Top module: `baud_clk_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, baud_clk and baud_stb are 0 and cfg_rdata reads 0x00.
- R2: Reading the register returns the base select in bits 7:6 and the divisor in bits 4:0. Bit 5 always reads 0, whatever value was written to it.
- R3: Select code 01 uses a base of the system clock divided by 2, so the baud_clk period is 2·k·2 system cycles.
- R4: Select code 10 divides the system clock by 8, and select code 11 divides it by 32. The baud_clk period is 2·k·8 and 2·k·32 system cycles respectively.
- R5: Select code 00 takes one base pulse per rising edge of ext_tick_in, after a two-flop synchronizer. With a periodic input of period T cycles, the baud_clk period is 2·k·T.
- R6: Any divisor k from 8 to 31 gives a baud_clk period of exactly 2·k base pulses.
- R7: Divisor values 0 to 7 act as 8.
- R8: baud_stb is high for exactly one cycle at a time. It is high exactly in the cycles where baud_clk has just changed level, so strobes are k base pulses apart.
- R9: While gen_en is low, baud_clk stays 0 and baud_stb stays 0.
- R10: In the cycle after a register write, baud_clk is 0, and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Generator enable; low holds the divider chain cleared |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| ext_tick_in | input | 1 | Asynchronous external timer output used as base source |
| baud_clk | output | 1 | Baud clock, 50% duty |
| baud_stb | output | 1 | One-cycle pulse on every baud_clk transition |

## Verification
Suppose the prescaler tap or the divisor counter holds a wrong value. Then the very next baud_clk period is wrong, by a factor of the prescale or by a few base pulses, so timing each source and divisor across two full periods exposes the fault within about 4·k·P cycles. If the toggle register and the strobe fall out of step, a strobe appears without an edge, or the reverse, in the first half period. A clear path that is stuck shows up in the first cycle after a write or after the enable drops.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int CFG_W   = 8;
    localparam int SEL_W   = 2;
    localparam int K_W     = 5;
    localparam int K_MIN   = 8;
    localparam int SEL_LSB = 6;
    localparam int K_LSB   = 0;
    localparam int N_PRE   = 3;

    typedef enum logic [SEL_W-1:0] {
        BASE_EXT   = 2'b00,
        BASE_DIV2  = 2'b01,
        BASE_DIV8  = 2'b10,
        BASE_DIV32 = 2'b11
    } base_sel_e;

    typedef struct packed {
        base_sel_e        sel;
        logic [K_W-1:0]   k;
    } cfg_t;

    // log2 of each fixed prescale tap, indexed by select code minus one
    function automatic int pre_log2(input int idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            default: return 5;
        endcase
    endfunction

    function automatic logic [K_W-1:0] clamp_k(input logic [K_W-1:0] k);
        return (k < K_W'(K_MIN)) ? K_W'(K_MIN) : k;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(input cfg_t c);
        logic [CFG_W-1:0] v;
        v = '0;
        v[SEL_LSB +: SEL_W] = c.sel;
        v[K_LSB +: K_W]     = c.k;
        return v;
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [CFG_W-1:0] rdata
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{sel: BASE_EXT, k: '0};
        end else if (wr) begin
            cfg_q.sel <= base_sel_e'(wdata[SEL_LSB +: SEL_W]);
            cfg_q.k   <= wdata[K_LSB +: K_W];
        end
    end

    assign cfg   = cfg_q;
    assign rdata = pack_cfg(cfg_q);

    a_r2_rsvd_reads_zero: assert property (@(posedge clk) disable iff (rst)
        wr |=> (rdata[5] == 1'b0) && (rdata[4:0] == $past(wdata[4:0])));

endmodule

// File: rtl/baud_base_tick.sv
module baud_base_tick
    import baud_gen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  base_sel_e sel,
    input  logic      ext_in,
    output logic      tick
);

    localparam int PRE_W = pre_log2(N_PRE - 1);

    // free-running prescale counter, cleared with the divider chain
    logic [PRE_W-1:0] pre_cnt_q;
    logic [N_PRE-1:0] tap;

    always_ff @(posedge clk) begin
        if (rst || clr) pre_cnt_q <= '0;
        else            pre_cnt_q <= pre_cnt_q + 1'b1;
    end

    for (genvar i = 0; i < N_PRE; i++) begin : g_tap
        localparam int LG = pre_log2(i);
        assign tap[i] = &pre_cnt_q[LG-1:0];
    end

    // external source: two-flop synchronizer plus rising-edge detect
    logic ext_m_q, ext_s_q, ext_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_m_q <= 1'b0;
            ext_s_q <= 1'b0;
            ext_d_q <= 1'b0;
        end else begin
            ext_m_q <= ext_in;
            ext_s_q <= ext_m_q;
            ext_d_q <= ext_s_q;
        end
    end

    logic ext_edge;
    assign ext_edge = ext_s_q & ~ext_d_q;

    always_comb begin
        unique case (sel)
            BASE_EXT:   tick = ext_edge & ~clr;
            BASE_DIV2:  tick = tap[0] & ~clr;
            BASE_DIV8:  tick = tap[1] & ~clr;
            default:    tick = tap[2] & ~clr;
        endcase
    end

    a_r3_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r5_ext_edge_single: assert property (@(posedge clk) disable iff (rst)
        ext_edge |=> !ext_edge);

endmodule

// File: rtl/baud_div_core.sv
module baud_div_core
    import baud_gen_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           tick,
    input  logic [K_W-1:0] k_eff,
    output logic           baud,
    output logic           stb
);

    logic [K_W-1:0] cnt_q;
    logic           baud_q, stb_q;
    logic           term;

    assign term = tick && (cnt_q == k_eff - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            baud_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= term;
            if (term) begin
                cnt_q  <= '0;
                baud_q <= ~baud_q;
            end else if (tick) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign baud = baud_q;
    assign stb  = stb_q;

    a_r7_count_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q < k_eff);

    a_r8_stb_one_cycle: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q);

    a_r8_edge_has_stb: assert property (@(posedge clk) disable iff (rst)
        (baud_q != $past(baud_q)) |-> (stb_q || $past(clr) || $past(rst)));

endmodule

// File: rtl/baud_clk_gen.sv
module baud_clk_gen
    import baud_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       gen_en,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       ext_tick_in,
    output logic       baud_clk,
    output logic       baud_stb
);

    cfg_t            cfg;
    logic            clr;
    logic            base_tick;
    logic [K_W-1:0]  k_eff;

    // a disabled generator or any register write restarts the chain
    assign clr   = ~gen_en | cfg_wr;
    assign k_eff = clamp_k(cfg.k);

    baud_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    baud_base_tick u_base (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .sel    (cfg.sel),
        .ext_in (ext_tick_in),
        .tick   (base_tick)
    );

    baud_div_core u_div (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .tick  (base_tick),
        .k_eff (k_eff),
        .baud  (baud_clk),
        .stb   (baud_stb)
    );

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> (!baud_clk && !baud_stb));

    a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !baud_clk);

endmodule

// File: tb/baud_clk_gen_test.sv
module baud_clk_gen_test;

    localparam int EXT_HALF = 3;
    localparam int EXT_PER  = 2 * EXT_HALF;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gen_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       ext_tick_in = 1'b0;
    logic       baud_clk, baud_stb;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (EXT_HALF) @(negedge clk);
            ext_tick_in = ~ext_tick_in;
        end
    end

    baud_clk_gen uut (
        .clk         (clk),
        .rst         (rst),
        .gen_en      (gen_en),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .ext_tick_in (ext_tick_in),
        .baud_clk    (baud_clk),
        .baud_stb    (baud_stb)
    );

    function automatic int exp_k(input int k);
        return (k < 8) ? 8 : k;
    endfunction

    function automatic int exp_pre(input int sel);
        case (sel)
            0:       return EXT_PER;
            1:       return 2;
            2:       return 8;
            default: return 32;
        endcase
    endfunction

    function automatic string src_tag(input int sel);
        case (sel)
            0:       return "R5";
            1:       return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic write_cfg(input int sel, input int k, input bit rsvd);
        logic [7:0] w;
        w = {sel[1:0], rsvd, k[4:0]};
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        // R10: output cleared right after the write
        check(baud_clk == 1'b0, "R10", "baud_clk after write", int'(baud_clk), 0);
        // R2: readback with bit 5 forced low
        check(cfg_rdata == {sel[1:0], 1'b0, k[4:0]}, "R2", "cfg readback",
              int'(cfg_rdata), int'({sel[1:0], 1'b0, k[4:0]}));
    endtask

    task automatic run_case(input int sel, input int k);
        int  per, half, limit, t, rises, last_rise, last_stb, mism;
        bit  prev;
        string ktag;
        write_cfg(sel, k, k[0]);
        per   = 2 * exp_k(k) * exp_pre(sel);
        half  = per / 2;
        limit = 4 * per + 200;
        ktag  = (k < 8) ? "R7" : "R6";
        t = 0; rises = 0; last_rise = -1; last_stb = -1; mism = 0;
        prev = baud_clk;
        while (rises < 3 && t < limit && !done) begin
            @(negedge clk);
            t++;
            if ((baud_clk != prev) != baud_stb) mism++;
            if (baud_stb) begin
                if (last_stb >= 0)
                    check(t - last_stb == half, "R8", "strobe spacing", t - last_stb, half);
                last_stb = t;
            end
            if (baud_clk && !prev) begin
                if (last_rise >= 0) begin
                    check(t - last_rise == per, src_tag(sel), "baud period", t - last_rise, per);
                    check(t - last_rise == per, ktag, "divisor period", t - last_rise, per);
                end
                last_rise = t;
                rises++;
            end
            prev = baud_clk;
        end
        check(rises == 3, src_tag(sel), "baud edges seen", rises, 3);
        check(mism == 0, "R8", "strobe without edge", mism, 0);
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_LIMIT, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int dk [4] = '{8, 9, 31, 3};
        int idle_bad;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(baud_clk == 0 && baud_stb == 0, "R1", "outputs in reset",
              int'({baud_clk, baud_stb}), 0);
        check(cfg_rdata == 8'h00, "R1", "rdata in reset", int'(cfg_rdata), 0);
        rst = 1'b0;
        @(negedge clk);
        check(baud_clk == 0 && baud_stb == 0, "R1", "outputs after reset",
              int'({baud_clk, baud_stb}), 0);
        gen_en = 1'b1;

        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 4; i++)
                run_case(s, dk[i]);

        for (int r = 0; r < 8; r++)
            run_case(int'($urandom % 4), int'($urandom % 32));

        // R9: disabled generator stays quiet
        write_cfg(1, 8, 1'b0);
        repeat (20) @(negedge clk);
        gen_en = 1'b0;
        @(negedge clk);
        idle_bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (baud_clk || baud_stb) idle_bad++;
        end
        check(idle_bad == 0, "R9", "activity while disabled", idle_bad, 0);
        gen_en = 1'b1;
        run_case(2, 12);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule